// File: doc/BRIEF.md
# Channel Deskew Delay and Pulse Stretcher

This block sits between the hit sampler and the coincidence logic of a trigger path. Each input channel delivers one 4-bit word per 4 ns clock cycle. Bit 0 of the word is the earliest 1 ns slot of the cycle and bit 3 is the latest. Every channel has its own delay setting in nanoseconds and its own width setting. The block moves each hit later by exactly that many nanoseconds, so that cable and port skew can be cancelled. It then turns every delayed hit into a level that lasts a whole number of clock cycles.

The delay is split into two parts. The fine part, the setting modulo 4, shifts the slot word by 0 to 3 bits, and bits that overflow carry into the next cycle. The coarse part, the setting divided by 4, is the read-address offset into a circular memory that all channels share and that is written once per cycle. The stretcher reloads a down-counter whenever any bit of the delayed word is set. Its output stays high while the counter is non-zero.

Top module: `skw_chan_deskew`

## Requirements
- R1: After a synchronous active-low reset, `slice_o` and `pulse_o` are all zero. They stay zero until a hit sampled after that reset has passed through the delay, even if the memory still holds hits from before the reset.
- R2: A delay setting below 12 behaves exactly like 12, and a setting above 128 behaves exactly like 128.
- R3: Let D be the effective delay. A hit in slot s (bit s) of the word sampled at clock edge k appears on `slice_o` bit (s+D) mod 4 just after edge k + floor((s+D)/4) + 1. `slice_o` is zero in the cycle before that.
- R4: With width code W, `pulse_o` goes high one cycle after the delayed hit appears on `slice_o`. It stays high for exactly W+1 cycles and then drops.
- R5: A delayed hit that arrives while the pulse is high restarts the width count. The pulse then ends W+1 cycles after the last delayed hit, with no gap in between.
- R6: Each channel uses only its own delay and width settings. The same hit on two channels with delays of 12 and 40 starts the two pulses 7 cycles apart.
- R7: A word with several bits set gives one pulse. When the fine shift spreads that word over two cycles, the pulse lasts W+2 cycles.
- R8: The range limits work: delays of 12, 127 and 128, and width codes 0 (1 cycle) and 15 (16 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 ns clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | NCH*4 | Sampled slot words, channel c in bits [4c+3:4c], bit 0 earliest |
| dly_cfg_i | input | NCH*8 | Per-channel delay in ns, clamped to 12..128 |
| wid_cfg_i | input | NCH*4 | Per-channel width code W, pulse lasts W+1 cycles |
| slice_o | output | NCH*4 | Delayed slot words, same layout as `hit_i` |
| pulse_o | output | NCH | Stretched per-channel level |

## Verification
The checks assume that the delay and width settings stay constant while a hit is on its way through the memory. They also assume that the memory depth is a power of two larger than the largest coarse offset of 32 cycles. The coarse range check therefore relies on the clamp always holding the offset between 3 and 32. The bench changes settings only after 60 idle cycles, which is longer than the deepest delay plus the widest pulse. Between scenarios it drives no hits at all.

// File: rtl/skw_pkg.sv
// Shared constants and types for the channel deskew block.
// Assumes a 4 ns clock carrying four 1 ns slots per word.
package skw_pkg;
    localparam int SLOTS      = 4;                  // 1 ns slots per cycle
    localparam int SLOT_W     = 2;                  // bits of the fine delay
    localparam int CFG_W      = 8;                  // delay setting width (ns)
    localparam int WID_W      = 4;                  // width code width
    localparam int CNT_W      = WID_W + 1;          // stretch counter width
    localparam int COARSE_W   = CFG_W - SLOT_W;     // coarse offset width
    localparam int DLY_MIN_NS = 12;
    localparam int DLY_MAX_NS = 128;
    localparam int COARSE_MIN = DLY_MIN_NS / SLOTS;
    localparam int COARSE_MAX = DLY_MAX_NS / SLOTS;

    typedef logic [SLOTS-1:0] slice_t;
endpackage

// File: rtl/skw_dly_decode.sv
// Clamps a delay setting in ns to the legal window and splits it into a
// whole-cycle offset and a sub-cycle slot shift. Purely combinational.
module skw_dly_decode
    import skw_pkg::*;
(
    input  logic [CFG_W-1:0]    cfg_i,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [SLOT_W-1:0]   fine_o
);
    logic [CFG_W-1:0] eff_ns;

    // Clamp the setting, then split it into cycle and slot parts.
    always_comb begin
        if (cfg_i < CFG_W'(DLY_MIN_NS))
            eff_ns = CFG_W'(DLY_MIN_NS);
        else if (cfg_i > CFG_W'(DLY_MAX_NS))
            eff_ns = CFG_W'(DLY_MAX_NS);
        else
            eff_ns = cfg_i;
        coarse_o = eff_ns[CFG_W-1:SLOT_W];
        fine_o   = eff_ns[SLOT_W-1:0];
    end
endmodule

// File: rtl/skw_subcycle_shift.sv
// Delays one channel's slot word by 0..3 ns. Slots pushed past the end of
// the cycle carry into the next cycle's word. Output is registered.
// Assumes fine_i is steady while hits are in flight.
module skw_subcycle_shift
    import skw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slice_t            hit_i,
    input  logic [SLOT_W-1:0] fine_i,
    output slice_t            shifted_o
);
    slice_t                 prev_q;
    slice_t                 sh_q;
    slice_t                 sh_next;
    logic [2*SLOTS-1:0]     pair;

    // Select the four slots that fall inside this cycle after the shift.
    always_comb begin
        pair = {hit_i, prev_q};
        for (int j = 0; j < SLOTS; j++)
            sh_next[j] = pair[SLOTS + j - int'(fine_i)];
    end

    // Keep the previous word for the carry and register the shifted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            sh_q   <= '0;
        end else begin
            prev_q <= hit_i;
            sh_q   <= sh_next;
        end
    end

    assign shifted_o = sh_q;

    // R3: with no fine shift, the word passes through unchanged.
    p_fine_passthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_i == '0) |=> (sh_q == $past(hit_i)));
endmodule

// File: rtl/skw_ring_delay.sv
// Circular memory shared by all channels and written every cycle. Each
// channel reads at its own coarse offset behind the write pointer. Until
// that many words have been written since reset, a read returns zero.
// Assumes DEPTH is a power of two larger than COARSE_MAX.
module skw_ring_delay
    import skw_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH*SLOTS-1:0]    wr_data_i,
    input  logic [NCH*COARSE_W-1:0] coarse_i,
    output logic [NCH*SLOTS-1:0]    rd_data_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = NCH * SLOTS;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] fill_q;

    // Store the current word set at the write pointer.
    always_ff @(posedge clk) begin
        mem[wr_ptr_q] <= wr_data_i;
    end

    // Advance the pointer and count writes since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + AW'(1);
            if (fill_q != '1)
                fill_q <= fill_q + AW'(1);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_tap
        logic [COARSE_W-1:0] coarse;
        logic [AW-1:0]       rd_addr;
        logic [DW-1:0]       rd_word;
        logic                ready;
        slice_t              tap_q;

        assign coarse  = coarse_i[c*COARSE_W +: COARSE_W];
        assign rd_addr = wr_ptr_q - AW'(coarse);
        assign rd_word = mem[rd_addr];
        assign ready   = (fill_q >= AW'(coarse));

        // Register this channel's delayed slot word, blank until filled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tap_q <= '0;
            else if (ready)
                tap_q <= rd_word[c*SLOTS +: SLOTS];
            else
                tap_q <= '0;
        end

        assign rd_data_o[c*SLOTS +: SLOTS] = tap_q;

        // R2: the offset coming from the decoder stays inside the clamp window.
        p_coarse_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (coarse >= COARSE_W'(COARSE_MIN)) && (coarse <= COARSE_W'(COARSE_MAX)));
    end
endmodule

// File: rtl/skw_pulse_stretch.sv
// Turns delayed slot words into a level that lasts W+1 whole cycles.
// Any delayed hit reloads the counter, including one during a pulse.
// Assumes width_i is steady while a pulse is active.
module skw_pulse_stretch
    import skw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  slice_t           slice_i,
    input  logic [WID_W-1:0] width_i,
    output logic             pulse_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             seen;

    assign seen = |slice_i;

    // Reload on a delayed hit, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (seen)
            cnt_q <= CNT_W'(width_i) + CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign pulse_o = (cnt_q != '0);

    // R4: a delayed hit raises the level in the next cycle.
    p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> pulse_o);
    // R4: the level ends once the last counted cycle has passed.
    p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && !seen) |=> !pulse_o);
    // R4: without a hit, a low level stays low.
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_o && !seen) |=> !pulse_o);
    // R5: a hit during an active pulse restarts the full count.
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && seen) |=> (cnt_q == CNT_W'($past(width_i)) + CNT_W'(1)));
endmodule

// File: rtl/skw_chan_deskew.sv
// Per-channel deskew: clamp and split the delay setting, shift by whole
// slots, delay by whole cycles through the shared ring, then stretch.
// Assumes the settings change only while no hits are in flight.
module skw_chan_deskew
    import skw_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*SLOTS-1:0] hit_i,
    input  logic [NCH*CFG_W-1:0] dly_cfg_i,
    input  logic [NCH*WID_W-1:0] wid_cfg_i,
    output logic [NCH*SLOTS-1:0] slice_o,
    output logic [NCH-1:0]       pulse_o
);
    logic [NCH*SLOTS-1:0]    shifted;
    logic [NCH*COARSE_W-1:0] coarse;
    logic [NCH*SLOTS-1:0]    delayed;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [SLOT_W-1:0] fine;

        skw_dly_decode i_decode (
            .cfg_i    (dly_cfg_i[c*CFG_W +: CFG_W]),
            .coarse_o (coarse[c*COARSE_W +: COARSE_W]),
            .fine_o   (fine)
        );

        skw_subcycle_shift i_shift (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit_i[c*SLOTS +: SLOTS]),
            .fine_i    (fine),
            .shifted_o (shifted[c*SLOTS +: SLOTS])
        );

        skw_pulse_stretch i_stretch (
            .clk     (clk),
            .rst_n   (rst_n),
            .slice_i (delayed[c*SLOTS +: SLOTS]),
            .width_i (wid_cfg_i[c*WID_W +: WID_W]),
            .pulse_o (pulse_o[c])
        );
    end

    skw_ring_delay #(
        .NCH   (NCH),
        .DEPTH (DEPTH)
    ) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data_i (shifted),
        .coarse_i  (coarse),
        .rd_data_o (delayed)
    );

    assign slice_o = delayed;
endmodule

// File: tb/test_skw_chan_deskew.sv
`timescale 1ns/1ps
module test_skw_chan_deskew;
    localparam int CLK_PERIOD = 4;
    localparam int NCH = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCH*4-1:0]   hit = '0;
    logic [NCH*8-1:0]   dly_cfg = '0;
    logic [NCH*4-1:0]   wid_cfg = '0;
    logic [NCH*4-1:0]   slice_o;
    logic [NCH-1:0]     pulse_o;

    int checks = 0;
    int errors = 0;
    int m_first [NCH];
    int m_len   [NCH];
    int m_rise  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    skw_chan_deskew #(.NCH(NCH), .DEPTH(512)) i_skw_chan_deskew (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .dly_cfg_i (dly_cfg),
        .wid_cfg_i (wid_cfg),
        .slice_o   (slice_o),
        .pulse_o   (pulse_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampd(input int d);
        if (d < 12) return 12;
        if (d > 128) return 128;
        return d;
    endfunction

    // Track first high cycle, high length and rising edges per channel.
    task automatic measure(input int n);
        logic [NCH-1:0] prev;
        prev = pulse_o;
        for (int c = 0; c < NCH; c++) begin
            m_first[c] = -1; m_len[c] = 0; m_rise[c] = 0;
        end
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (pulse_o[c]) begin
                    m_len[c]++;
                    if (m_first[c] < 0) m_first[c] = i;
                    if (!prev[c]) m_rise[c]++;
                end
            end
            prev = pulse_o;
        end
    endtask

    task automatic idle(input int n);
        hit = '0;
        repeat (n) @(negedge clk);
    endtask

    // R1: outputs are quiet after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        dly_cfg = {NCH{8'd12}};
        wid_cfg = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk(slice_o == '0 && pulse_o == '0, "R1 reset state", int'(slice_o), 0);
        measure(40);
        chk(m_len[0] + m_len[1] + m_len[2] + m_len[3] == 0, "R1 quiet after reset",
            m_len[0] + m_len[1] + m_len[2] + m_len[3], 0);
    endtask

    // R1: hits stored before a reset never reach the outputs afterwards.
    task automatic t_stale();
        dly_cfg[7:0] = 8'd12;
        wid_cfg[3:0] = 4'd0;
        hit = '0;
        hit[0] = 1'b1;
        repeat (600) @(negedge clk);
        hit = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(slice_o == '0 && pulse_o == '0, "R1 reset clears outputs", int'(pulse_o), 0);
        measure(40);
        chk(m_len[0] == 0, "R1 no stale hit after reset", m_len[0], 0);
    endtask

    // R3 R4 R8: a single hit with the given slot, delay and width code.
    task automatic run_hit(input int ch, input int slot, input int dns,
                           input int wcode, input string req);
        int de, lat, pos;
        dly_cfg[ch*8 +: 8] = 8'(dns);
        wid_cfg[ch*4 +: 4] = 4'(wcode);
        idle(60);
        hit[ch*4 + slot] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hit = '0;
        de  = clampd(dns);
        lat = (slot + de) / 4 + 1;
        pos = (slot + de) % 4;
        repeat (lat - 1) @(negedge clk);
        chk(slice_o[ch*4 +: 4] == 4'd0 && !pulse_o[ch], {req, " early quiet"},
            int'(slice_o[ch*4 +: 4]), 0);
        @(negedge clk);
        chk(slice_o[ch*4 +: 4] == (4'b0001 << pos), {req, " slot position"},
            int'(slice_o[ch*4 +: 4]), int'(4'b0001 << pos));
        chk(!pulse_o[ch], {req, " pulse not yet"}, int'(pulse_o[ch]), 0);
        for (int i = 0; i <= wcode; i++) begin
            @(negedge clk);
            chk(pulse_o[ch], {req, " R4 pulse high"}, int'(pulse_o[ch]), 1);
        end
        @(negedge clk);
        chk(!pulse_o[ch], {req, " R4 pulse ends"}, int'(pulse_o[ch]), 0);
    endtask

    task automatic t_singles();
        run_hit(0, 0, 12, 0, "R3 R8 d12 w1");
        run_hit(1, 3, 13, 3, "R3 carry d13");
        run_hit(2, 2, 55, 7, "R3 d55");
        run_hit(3, 1, 128, 15, "R3 R8 d128 w16");
        run_hit(0, 1, 127, 4, "R3 R8 d127");
    endtask

    task automatic t_clamp();
        run_hit(1, 0, 5, 2, "R2 low clamp");
        run_hit(2, 3, 200, 1, "R2 high clamp");
        run_hit(3, 2, 0, 0, "R2 zero setting");
    endtask

    // R5: a second hit during the pulse extends it.
    task automatic t_retrigger();
        dly_cfg[3*8 +: 8] = 8'd20;
        wid_cfg[3*4 +: 4] = 4'd7;
        idle(60);
        hit[12] = 1'b1;
        @(negedge clk);
        hit = '0;
        repeat (2) @(negedge clk);
        hit[12] = 1'b1;
        @(negedge clk);
        hit = '0;
        measure(70);
        chk(m_first[3] == 4, "R5 retrigger start", m_first[3], 4);
        chk(m_len[3] == 11, "R5 retrigger length", m_len[3], 11);
        chk(m_rise[3] == 1, "R5 retrigger no gap", m_rise[3], 1);
    endtask

    // R7: full words, unspread and spread by the fine shift.
    task automatic t_multibit(input int dns, input int exp_len);
        dly_cfg[2*8 +: 8] = 8'(dns);
        wid_cfg[2*4 +: 4] = 4'd1;
        idle(60);
        hit[2*4 +: 4] = 4'b1111;
        @(negedge clk);
        hit = '0;
        measure(70);
        chk(m_first[2] == 5, "R7 word start", m_first[2], 5);
        chk(m_len[2] == exp_len, "R7 word length", m_len[2], exp_len);
        chk(m_rise[2] == 1, "R7 single pulse", m_rise[2], 1);
    endtask

    // R6: two channels with different settings see the same hit.
    task automatic t_indep();
        dly_cfg = {8'd12, 8'd12, 8'd40, 8'd12};
        wid_cfg = {4'd0, 4'd0, 4'd5, 4'd0};
        idle(60);
        hit[0] = 1'b1;
        hit[4] = 1'b1;
        @(negedge clk);
        hit = '0;
        measure(70);
        chk(m_first[0] == 5, "R6 ch0 start", m_first[0], 5);
        chk(m_first[1] == 12, "R6 ch1 start", m_first[1], 12);
        chk(m_len[0] == 1, "R6 ch0 width", m_len[0], 1);
        chk(m_len[1] == 6, "R6 ch1 width", m_len[1], 6);
        chk(m_len[2] == 0 && m_len[3] == 0, "R6 idle channels quiet",
            m_len[2] + m_len[3], 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stale();
        t_singles();
        t_clamp();
        t_retrigger();
        t_multibit(12, 2);
        t_multibit(13, 3);
        t_indep();
        idle(5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule